// File: doc/BRIEF.md
# Mixed-Access Control and Status Register Bank

This block is a small register file on a plain processor bus. The bus has a read strobe, a write strobe, a 4-bit address and an 8-bit write-data input. Read data comes back through a flop. The bank holds a fixed set of fields, and each field has one access behaviour:

- plain read/write configuration bytes;
- a read-only version value taken from an input;
- a write-only byte;
- two sticky status bits, one cleared by writing a 1 and one cleared by reading it;
- a saturating event counter that clears when read;
- a one-cycle pulse command;
- a 16-bit configuration value split over two addresses.

Configuration fields drive output ports. Status and event inputs come from the surrounding logic.

An address decoder turns the bus strobes into one-hot per-address select lines. A datapath holds the fields and builds the read multiplexer. A parameter can add one extra register stage to the read path. With that stage present, read data arrives one cycle later. All flops clear on an asynchronous active-low reset.

Top module: `csrBank`

## Requirements
- R1: After reset every configuration output, `pulseOut` and `rdData` are zero. Sticky bits and the counter also read zero.
- R2: Address 0 is an 8-bit read/write field driving `cfgByte`. Address 2 bits 3:0 are a read/write field driving `cfgNibble`.
- R3: A read of address 1 returns the `versionIn` input.
- R4: Address 2 bit 6 is sticky. It sets when `errEvent` is 1 and clears on a write to address 2 with data bit 6 set. If `errEvent` is 1 in the clearing cycle, the bit stays 1.
- R5: Address 3 bit 0 is sticky on `corEvent`. A read of address 3 returns the value before the read, and the bit clears after the read unless `corEvent` is 1 in that same cycle.
- R6: Address 4 counts cycles with `cntEvent` high and saturates at 255. A read returns the count and clears it to 0, or to 1 if `cntEvent` is high in the read cycle.
- R7: A write to address 5 with data bit 0 set makes `pulseOut` high for exactly the next cycle. Otherwise `pulseOut` is low, and address 5 reads as zero.
- R8: Address 6 is the low byte and address 7 the high byte of the 16-bit read/write field on `wideCfg`.
- R9: Address 8 is write-only and drives `woCfg`. A read of it returns zero.
- R10: Addresses 9 to 15 read as zero and ignore writes. Field bits not listed above read as zero.
- R11: With no extra read stage, `rdData` takes the selected value one cycle after a read strobe and holds its value when no read occurs. With both strobes in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| versionIn | input | 8 | Read-only version value |
| errEvent | input | 1 | Event for write-1-to-clear sticky bit |
| corEvent | input | 1 | Event for clear-on-read sticky bit |
| cntEvent | input | 1 | Counter increment event |
| cfgByte | output | 8 | Address 0 field |
| cfgNibble | output | 4 | Address 2 bits 3:0 |
| pulseOut | output | 1 | One-cycle command pulse |
| wideCfg | output | 16 | 16-bit field from addresses 6 and 7 |
| woCfg | output | 8 | Write-only field at address 8 |

## Verification
Random cycles mix reads, writes, simultaneous strobes and sparse events over all sixteen addresses. This separates correct address decoding from aliasing between fields and between mapped and unmapped addresses. Directed sequences cover the cases where an event and a clear land in the same cycle. They show whether the set wins over the clear for both sticky kinds and for the counter's clear-on-read reload. A long run of counter events with no read tells saturation apart from wrap-around. Idle cycles between reads show whether read data holds its value or follows the multiplexer.

// File: rtl/csrBankPkg.sv
package csrBankPkg;
  parameter int ADDR_W   = 4;
  parameter int DATA_W   = 8;
  localparam int NUM_REGS = 1 << ADDR_W;

  localparam int A_CFG     = 0;
  localparam int A_VERSION = 1;
  localparam int A_CTRL    = 2;
  localparam int A_CORBIT  = 3;
  localparam int A_COUNT   = 4;
  localparam int A_PULSE   = 5;
  localparam int A_WIDE_LO = 6;
  localparam int A_WIDE_HI = 7;
  localparam int A_WONLY   = 8;

  localparam int NIBBLE_W  = 4;
  localparam int ERR_BIT   = 6;
  localparam int PULSE_BIT = 0;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic [NUM_REGS-1:0] rdSel;
    logic                rdAny;
  } csrStrobes_t;
endpackage

// File: rtl/csrBankCtrl.sv
module csrBankCtrl
  import csrBankPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output csrStrobes_t       strobes
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    always_comb begin
      strobes.wrSel[i] = wrEn && (addr == ADDR_W'(i));
      strobes.rdSel[i] = rdEn && (addr == ADDR_W'(i));
    end
  end
  assign strobes.rdAny = rdEn;

  a_r10_wr_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrSel));
  a_r11_rd_sel_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdSel != '0) |-> rdEn);
endmodule

// File: rtl/csrBankDatapath.sv
module csrBankDatapath
  import csrBankPkg::*;
#(
  parameter int READ_PIPE = 0
)(
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] versionIn,
  input  logic              errEvent,
  input  logic              corEvent,
  input  logic              cntEvent,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] cfgByte,
  output logic [NIBBLE_W-1:0] cfgNibble,
  output logic              pulseOut,
  output logic [2*DATA_W-1:0] wideCfg,
  output logic [DATA_W-1:0] woCfg
);
  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  logic errSticky, corSticky;
  logic [DATA_W-1:0] evCount;
  logic [DATA_W-1:0] regView [NUM_REGS];
  logic [DATA_W-1:0] muxOut;

  // configuration fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgByte   <= '0;
      cfgNibble <= '0;
      wideCfg   <= '0;
      woCfg     <= '0;
      pulseOut  <= 1'b0;
    end else begin
      if (strobes.wrSel[A_CFG])     cfgByte   <= wrData;
      if (strobes.wrSel[A_CTRL])    cfgNibble <= wrData[NIBBLE_W-1:0];
      if (strobes.wrSel[A_WIDE_LO]) wideCfg[DATA_W-1:0] <= wrData;
      if (strobes.wrSel[A_WIDE_HI]) wideCfg[2*DATA_W-1:DATA_W] <= wrData;
      if (strobes.wrSel[A_WONLY])   woCfg     <= wrData;
      pulseOut <= strobes.wrSel[A_PULSE] && wrData[PULSE_BIT];
    end
  end

  // status fields: set events win over clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errSticky <= 1'b0;
      corSticky <= 1'b0;
      evCount   <= '0;
    end else begin
      errSticky <= (errSticky && !(strobes.wrSel[A_CTRL] && wrData[ERR_BIT])) || errEvent;
      corSticky <= (corSticky && !strobes.rdSel[A_CORBIT]) || corEvent;
      if (strobes.rdSel[A_COUNT])
        evCount <= DATA_W'(cntEvent);
      else if (cntEvent && evCount != CNT_MAX)
        evCount <= evCount + 1'b1;
    end
  end

  // read view per address
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) regView[i] = '0;
    regView[A_CFG]     = cfgByte;
    regView[A_VERSION] = versionIn;
    regView[A_CTRL][NIBBLE_W-1:0] = cfgNibble;
    regView[A_CTRL][ERR_BIT]      = errSticky;
    regView[A_CORBIT][0]          = corSticky;
    regView[A_COUNT]   = evCount;
    regView[A_WIDE_LO] = wideCfg[DATA_W-1:0];
    regView[A_WIDE_HI] = wideCfg[2*DATA_W-1:DATA_W];
  end

  always_comb begin
    muxOut = '0;
    for (int i = 0; i < NUM_REGS; i++)
      muxOut = muxOut | ({DATA_W{strobes.rdSel[i]}} & regView[i]);
  end

  if (READ_PIPE != 0) begin : g_pipe
    logic [DATA_W-1:0] stageData;
    logic              stagePend;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageData <= '0;
        stagePend <= 1'b0;
        rdData    <= '0;
      end else begin
        stagePend <= strobes.rdAny;
        if (strobes.rdAny) stageData <= muxOut;
        if (stagePend)     rdData    <= stageData;
      end
    end
  end else begin : g_direct
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rdData <= '0;
      else if (strobes.rdAny) rdData <= muxOut;
    end
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.rdAny |=> $stable(rdData));
  end

  a_r4_sticky_set: assert property (@(posedge clk) disable iff (!rstN)
    errEvent |=> errSticky);
  a_r5_cor_set: assert property (@(posedge clk) disable iff (!rstN)
    corEvent |=> corSticky);
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (evCount == CNT_MAX && !strobes.rdSel[A_COUNT]) |=> evCount == CNT_MAX);
  a_r7_pulse_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrSel[A_PULSE] |=> !pulseOut);
  a_r9_wonly_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrSel[A_WONLY] |=> $stable(woCfg));
endmodule

// File: rtl/csrBank.sv
module csrBank
  import csrBankPkg::*;
#(
  parameter int READ_PIPE = 0
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic [3:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic [7:0]  versionIn,
  input  logic        errEvent,
  input  logic        corEvent,
  input  logic        cntEvent,
  output logic [7:0]  cfgByte,
  output logic [3:0]  cfgNibble,
  output logic        pulseOut,
  output logic [15:0] wideCfg,
  output logic [7:0]  woCfg
);
  csrStrobes_t strobes;

  csrBankCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .addr    (addr),
    .strobes (strobes)
  );

  csrBankDatapath #(.READ_PIPE(READ_PIPE)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .versionIn (versionIn),
    .errEvent  (errEvent),
    .corEvent  (corEvent),
    .cntEvent  (cntEvent),
    .rdData    (rdData),
    .cfgByte   (cfgByte),
    .cfgNibble (cfgNibble),
    .pulseOut  (pulseOut),
    .wideCfg   (wideCfg),
    .woCfg     (woCfg)
  );
endmodule

// File: tb/test_csrBank.sv
module test_csrBank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] versionIn = 8'hA5;
  logic errEvent = 1'b0, corEvent = 1'b0, cntEvent = 1'b0;
  logic [7:0] rdData, cfgByte, woCfg;
  logic [3:0] cfgNibble;
  logic pulseOut;
  logic [15:0] wideCfg;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [7:0]  m0 = '0, mCnt = '0, m8 = '0, mRd = '0;
  logic [3:0]  m2n = '0;
  logic        mErr = 1'b0, mCor = 1'b0;
  logic [15:0] m16 = '0;

  always #10 clk = ~clk;

  csrBank i_csrBank (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .versionIn(versionIn),
    .errEvent(errEvent), .corEvent(corEvent), .cntEvent(cntEvent),
    .cfgByte(cfgByte), .cfgNibble(cfgNibble), .pulseOut(pulseOut),
    .wideCfg(wideCfg), .woCfg(woCfg)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] viewOf(input logic [3:0] a);
    case (a)
      4'd0: viewOf = m0;
      4'd1: viewOf = versionIn;
      4'd2: viewOf = {1'b0, mErr, 2'b00, m2n};
      4'd3: viewOf = {7'b0, mCor};
      4'd4: viewOf = mCnt;
      4'd6: viewOf = m16[7:0];
      4'd7: viewOf = m16[15:8];
      default: viewOf = 8'h00;
    endcase
  endfunction

  // one bus cycle: drive, clock, check, update model
  task automatic step(input logic r, input logic w, input logic [3:0] a, input logic [7:0] d,
                      input logic eErr, input logic eCor, input logic eCnt, input string tag);
    logic expPulse;
    @(negedge clk);
    rdEn = r; wrEn = w; addr = a; wrData = d;
    errEvent = eErr; corEvent = eCor; cntEvent = eCnt;
    if (r) mRd = viewOf(a);
    expPulse = w && a == 4'd5 && d[0];
    mErr = (mErr && !(w && a == 4'd2 && d[6])) || eErr;
    mCor = (mCor && !(r && a == 4'd3)) || eCor;
    if (r && a == 4'd4) mCnt = {7'b0, eCnt};
    else if (eCnt && mCnt != 8'hFF) mCnt = mCnt + 8'd1;
    if (w) begin
      case (a)
        4'd0: m0 = d;
        4'd2: m2n = d[3:0];
        4'd6: m16[7:0] = d;
        4'd7: m16[15:8] = d;
        4'd8: m8 = d;
        default: ;
      endcase
    end
    @(posedge clk);
    #5;
    chk(rdData == mRd, {tag, " R11 rdData"}, rdData, mRd);
    chk(pulseOut == expPulse, "R7 pulseOut", pulseOut, expPulse);
    chk(cfgByte == m0 && cfgNibble == m2n, "R2 cfg outputs", {cfgByte, cfgNibble}, {m0, m2n});
    chk(wideCfg == m16 && woCfg == m8, "R8/R9 wide and write-only outputs", {wideCfg, woCfg}, {m16, m8});
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 4'd0, 8'd0, 1'b0, 1'b0, 1'b0, "idle");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    chk(rdData == 0 && cfgByte == 0 && cfgNibble == 0 && pulseOut == 0 &&
        wideCfg == 0 && woCfg == 0, "R1 reset outputs", rdData, 0);
    rstN = 1'b1;
    for (int a = 0; a < 16; a++) step(1'b1, 1'b0, 4'(a), 8'd0, 1'b0, 1'b0, 1'b0, "R1 reset readback");

    // R2, R3, R8, R9 directed
    step(1'b0, 1'b1, 4'd0, 8'h3C, 0, 0, 0, "R2 write");
    step(1'b1, 1'b0, 4'd0, 8'h00, 0, 0, 0, "R2 read");
    step(1'b0, 1'b1, 4'd2, 8'hBF, 0, 0, 0, "R2 nibble write no set");
    step(1'b1, 1'b0, 4'd2, 8'h00, 0, 0, 0, "R2 R10 nibble read");
    step(1'b1, 1'b0, 4'd1, 8'h00, 0, 0, 0, "R3 version read");
    step(1'b0, 1'b1, 4'd6, 8'h34, 0, 0, 0, "R8 low");
    step(1'b0, 1'b1, 4'd7, 8'h12, 0, 0, 0, "R8 high");
    step(1'b1, 1'b0, 4'd7, 8'h00, 0, 0, 0, "R8 read high");
    step(1'b0, 1'b1, 4'd8, 8'h77, 0, 0, 0, "R9 write");
    step(1'b1, 1'b0, 4'd8, 8'h00, 0, 0, 0, "R9 read zero");

    // R4: set, clear, set wins over clear
    step(1'b0, 1'b0, 4'd0, 8'h00, 1, 0, 0, "R4 event");
    step(1'b1, 1'b0, 4'd2, 8'h00, 0, 0, 0, "R4 set seen");
    step(1'b0, 1'b1, 4'd2, 8'h40, 1, 0, 0, "R4 clear with event");
    step(1'b1, 1'b0, 4'd2, 8'h00, 0, 0, 0, "R4 still set");
    chk(rdData[6] == 1'b1, "R4 set wins", rdData[6], 1);
    step(1'b0, 1'b1, 4'd2, 8'h40, 0, 0, 0, "R4 clear");
    step(1'b1, 1'b0, 4'd2, 8'h00, 0, 0, 0, "R4 cleared");
    chk(rdData[6] == 1'b0, "R4 cleared bit", rdData[6], 0);

    // R5: clear on read, event in read cycle keeps it
    step(1'b0, 1'b0, 4'd0, 8'h00, 0, 1, 0, "R5 event");
    step(1'b1, 1'b0, 4'd3, 8'h00, 0, 1, 0, "R5 read with event");
    step(1'b1, 1'b0, 4'd3, 8'h00, 0, 0, 0, "R5 kept");
    chk(rdData == 8'h01, "R5 set wins on read", rdData, 1);
    step(1'b1, 1'b0, 4'd3, 8'h00, 0, 0, 0, "R5 cleared");
    chk(rdData == 8'h00, "R5 clear after read", rdData, 0);

    // R6: saturation and reload
    for (int i = 0; i < 300; i++) step(1'b0, 1'b0, 4'd0, 8'h00, 0, 0, 1, "R6 count");
    step(1'b1, 1'b0, 4'd4, 8'h00, 0, 0, 1, "R6 read saturated");
    chk(rdData == 8'hFF, "R6 saturation", rdData, 8'hFF);
    step(1'b1, 1'b0, 4'd4, 8'h00, 0, 0, 0, "R6 reload one");
    chk(rdData == 8'h01, "R6 event on read counts one", rdData, 1);

    // R7: pulse, bit 0 clear gives none
    step(1'b0, 1'b1, 4'd5, 8'h01, 0, 0, 0, "R7 pulse");
    idle();
    step(1'b0, 1'b1, 4'd5, 8'hFE, 0, 0, 0, "R7 no pulse");
    step(1'b1, 1'b0, 4'd5, 8'h00, 0, 0, 0, "R7 read zero");

    // R10: unmapped write ignored
    step(1'b0, 1'b1, 4'd12, 8'hFF, 0, 0, 0, "R10 write");
    step(1'b1, 1'b0, 4'd12, 8'h00, 0, 0, 0, "R10 read");
    chk(rdData == 8'h00, "R10 unmapped zero", rdData, 0);

    // R11: simultaneous strobes read old value, hold on idle
    step(1'b1, 1'b1, 4'd0, 8'h99, 0, 0, 0, "R11 both strobes");
    idle();
    idle();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      automatic logic [31:0] rv = $urandom;
      if (i % 500 == 0) versionIn = 8'($urandom);
      step(rv[0], rv[1], rv[5:2], rv[13:6], rv[16:14] == 0, rv[19:17] == 0,
           rv[21:20] != 0, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule